// File: doc/BRIEF.md
# Local-Bus Interrupt Combiner

This block gathers a set of level-sensitive interrupt request lines from local-bus peripherals into one interrupt output for the processor. A per-line enable mask selects which requests may raise the output. Software reaches the block through a small 16-bit register window with two locations. One location is the enable mask. The other returns a vector code for the winning pending line. Software can add that code to the base of a handler table without further decoding.

The request lines are sampled into a source register on every clock, so each source bit simply follows its input. A line is pending when its source bit and its mask bit are both set. The lowest-numbered pending line has priority. The combined output is registered. It reflects a new input level or a new mask one clock after the change. Register accesses are plain single-cycle strobes, with no handshake. Read data is combinational from the address and the current register state.

Top module: `lbi_combiner`

## Requirements
- R1: Each source bit takes the level of its request input at every rising clock edge. It is set while the input is high and cleared once the input is low. Nothing is latched.
- R2: `irq_out` is high exactly when source AND mask is non-zero. It is registered, so it changes at the same clock edge that captures a new input level or a new mask.
- R3: A read at byte offset 0 returns ((index of the lowest-numbered pending line) + 1) × 4 as a 16-bit value. It returns 0 when no line is pending. The result is always a multiple of 4.
- R4: Byte offset 2 holds the enable mask. Bit n enables line n. A write with `reg_wen` high stores `reg_wdata` at the clock edge. A read returns the stored mask.
- R5: While `rst_n` is low and right after reset, the mask reads 0x0010 (only line 4 enabled), the source register is 0 and `irq_out` is low.
- R6: A read at any offset other than 0 or 2 returns 0. A write to any other offset changes neither the mask nor `irq_out`.
- R7: Reading the vector location any number of times changes neither the source state, the mask nor `irq_out`.
- R8: When several lines are pending, the vector names the lowest-numbered one, whatever the higher lines do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 16 | Level-sensitive request lines, bit n is line n |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The bench builds the block with its default parameters: 16 lines, a 16-bit data path, a 12-bit offset and a reset mask of 0x0010. With 16 lines, line 15 is reachable, so the largest vector code (64) and the widest spread between competing lines are both exercised. The reset mask value makes line 4 the only source that fires before software writes the mask. This lets the bench show that other asserted lines stay silent until they are enabled.

// File: rtl/lbi_pkg.sv
package lbi_pkg;
  localparam int LINES_DEF  = 16;
  localparam int DATA_W_DEF = 16;
  localparam int ADDR_W_DEF = 12;
  localparam int VEC_OFS    = 0;
  localparam int MASK_OFS   = 2;
  localparam int VEC_SHIFT  = 2;
endpackage

// File: rtl/lbi_level_capture.sv
module lbi_level_capture #(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_in,
  output logic [LINES-1:0] src_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) src_q <= '0;
    else        src_q <= req_in;
  end
endmodule

// File: rtl/lbi_mask_reg.sv
module lbi_mask_reg #(
  parameter int             LINES    = 16,
  parameter logic [LINES-1:0] RST_VAL = 16'h0010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [LINES-1:0] wr_val,
  output logic [LINES-1:0] mask_d,
  output logic [LINES-1:0] mask_q
);
  always_comb mask_d = wr_hit ? wr_val : mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= RST_VAL;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/lbi_prio_vec.sv
module lbi_prio_vec #(
  parameter int LINES  = 16,
  parameter int DATA_W = 16,
  parameter int SHIFT  = 2
) (
  input  logic [LINES-1:0]  pend,
  output logic [DATA_W-1:0] vec
);
  always_comb begin
    vec = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend[i]) vec = DATA_W'((i + 1) << SHIFT);
    end
  end
endmodule

// File: rtl/lbi_combiner.sv
module lbi_combiner #(
  parameter int               LINES    = lbi_pkg::LINES_DEF,
  parameter int               DATA_W   = lbi_pkg::DATA_W_DEF,
  parameter int               ADDR_W   = lbi_pkg::ADDR_W_DEF,
  parameter logic [LINES-1:0] MASK_RST = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  irq_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_VEC  = ADDR_W'(lbi_pkg::VEC_OFS);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(lbi_pkg::MASK_OFS);

  logic [LINES-1:0]  src_q;
  logic [LINES-1:0]  mask_d;
  logic [LINES-1:0]  mask_q;
  logic [DATA_W-1:0] vec;
  logic              mask_hit;
  logic              irq_q;

  assign mask_hit = reg_wen && (reg_addr == A_MASK);

  lbi_level_capture #(.LINES(LINES)) u_cap (
    .clk(clk), .rst_n(rst_n), .req_in(irq_req), .src_q(src_q)
  );

  lbi_mask_reg #(.LINES(LINES), .RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_hit(mask_hit),
    .wr_val(reg_wdata[LINES-1:0]), .mask_d(mask_d), .mask_q(mask_q)
  );

  lbi_prio_vec #(.LINES(LINES), .DATA_W(DATA_W), .SHIFT(lbi_pkg::VEC_SHIFT)) u_prio (
    .pend(src_q & mask_q), .vec(vec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(irq_req & mask_d);
  end
  assign irq_out = irq_q;

  always_comb begin
    unique case (reg_addr)
      A_VEC:   reg_rdata = vec;
      A_MASK:  reg_rdata = DATA_W'(mask_q);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lbi_checker.sv
module lbi_checker #(
  parameter int LINES  = 16,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LINES-1:0]  irq_req,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wen,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq_out,
  input logic [LINES-1:0]  src_q,
  input logic [LINES-1:0]  mask_q
);
  assert_src_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> src_q == $past(irq_req));

  assert_irq_tracks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == |($past(irq_req) & mask_q));

  assert_vec_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(0) && !irq_out) |-> reg_rdata == '0);

  assert_vec_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(0) && irq_out) |-> (reg_rdata != '0 && reg_rdata[1:0] == 2'b00));

  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(2)) |=> mask_q == $past(reg_wdata[LINES-1:0]));

  assert_stray_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr != ADDR_W'(2)) |=> $stable(mask_q));

  assert_stray_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != ADDR_W'(0) && reg_addr != ADDR_W'(2)) |-> reg_rdata == '0);
endmodule

bind lbi_combiner lbi_checker #(.LINES(LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
  .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .irq_out(irq_out), .src_q(src_q), .mask_q(mask_q)
);

// File: tb/sim_lbi_combiner.sv
module sim_lbi_combiner;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_req = '0;
  logic [11:0] reg_addr = '0;
  logic        reg_wen = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [15:0] m_src = '0;
  logic [15:0] m_mask = 16'h0010;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbi_combiner u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .reg_addr(reg_addr),
    .reg_wen(reg_wen), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  function automatic logic [15:0] model_read(input logic [11:0] a);
    logic [15:0] p;
    p = m_src & m_mask;
    if (a == 12'd0) begin
      for (int k = 0; k < 16; k++)
        if (p[k]) return 16'((k + 1) * 4);
      return 16'd0;
    end
    if (a == 12'd2) return m_mask;
    return 16'd0;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src  <= '0;
      m_mask <= 16'h0010;
    end else begin
      m_src <= irq_req;
      if (reg_wen && reg_addr == 12'd2) m_mask <= reg_wdata;
    end
  end

  // per-clock comparison against the model (R1 R2 R3 R4 R5 R6)
  always @(negedge clk) begin
    if (!done) begin
      chk("R2 irq_out", {15'd0, irq_out}, {15'd0, |(m_src & m_mask)});
      chk("R3 rdata", reg_rdata, model_read(reg_addr));
    end
  end

  task automatic step(); @(posedge clk); #2; endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    step();
    reg_wen = 1'b0;
  endtask

  task automatic rd_at_neg(input logic [11:0] a, output logic [15:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    irq_req = 16'hFFFF;
    repeat (3) step();
    // R5: under reset
    rd_at_neg(12'd2, d); chk("R5 mask in reset", d, 16'h0010);
    chk("R5 irq in reset", {15'd0, irq_out}, 16'd0);
    irq_req = '0;
    rst_n = 1'b1;
    step();
    rd_at_neg(12'd0, d); chk("R5 vector after reset", d, 16'd0);

    // R1/R2: line 3 masked off, line 4 enabled by reset mask
    irq_req = 16'h0008; step();
    rd_at_neg(12'd0, d); chk("R2 masked line silent", d, 16'd0);
    chk("R2 irq low masked", {15'd0, irq_out}, 16'd0);
    irq_req = 16'h0018; step();
    rd_at_neg(12'd0, d); chk("R3 line4 vector", d, 16'd20);
    chk("R2 irq high", {15'd0, irq_out}, 16'd1);

    // R4/R8: open all lines, line 3 wins over 4
    wr(12'd2, 16'hFFFF);
    rd_at_neg(12'd2, d); chk("R4 mask readback", d, 16'hFFFF);
    rd_at_neg(12'd0, d); chk("R8 lowest wins", d, 16'd16);
    irq_req = 16'hF001; step();
    rd_at_neg(12'd0, d); chk("R8 line0 wins", d, 16'd4);

    // R3: highest line alone gives largest code
    wr(12'd2, 16'h8000);
    irq_req = 16'hFFFF; step();
    rd_at_neg(12'd0, d); chk("R3 line15 vector", d, 16'd64);

    // R7: repeated vector reads change nothing
    for (int n = 0; n < 4; n++) begin
      rd_at_neg(12'd0, d); chk("R7 stable vector", d, 16'd64);
    end
    chk("R7 irq kept", {15'd0, irq_out}, 16'd1);
    rd_at_neg(12'd2, d); chk("R7 mask kept", d, 16'h8000);

    // R1: dropping the level clears the source
    irq_req = 16'h7FFF; step();
    rd_at_neg(12'd0, d); chk("R1 level drop", d, 16'd0);
    chk("R1 irq low", {15'd0, irq_out}, 16'd0);

    // R6: stray offsets
    wr(12'd4, 16'h0001);
    wr(12'd3, 16'h0001);
    rd_at_neg(12'd2, d); chk("R6 mask untouched", d, 16'h8000);
    chk("R6 irq untouched", {15'd0, irq_out}, 16'd0);
    rd_at_neg(12'd6, d); chk("R6 stray read", d, 16'd0);
    rd_at_neg(12'hFFE, d); chk("R6 far read", d, 16'd0);

    // R4: write takes effect on irq_out at the write edge
    wr(12'd2, 16'h0002);
    chk("R4 irq after mask write", {15'd0, irq_out}, 16'd1);
    rd_at_neg(12'd0, d); chk("R4 vector after write", d, 16'd8);
    wr(12'd2, 16'h0000);
    chk("R2 mask zero", {15'd0, irq_out}, 16'd0);

    // walking single line
    wr(12'd2, 16'hFFFF);
    for (int k = 0; k < 16; k++) begin
      irq_req = 16'(1 << k); step();
      rd_at_neg(12'd0, d); chk("R3 walk", d, 16'((k + 1) * 4));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule